// File: doc/BRIEF.md
# PLL Enable and Lock Sequencer

This block is the digital control layer that sits beside an analog PLL macro. Software programs it through a small register port: a run-enable bit, an on-demand bit, a reference-source select, a loop-bandwidth select, a divider write-protect bit and one enable bit for each output. The block drives the analog enable pin and waits for the macro to report lock. Only after that lock does it ungate the enabled output clocks. Each output clock gate is glitch-free and latch-based, and its enable is resynchronised into that output's own clock domain.

The block decides whether the PLL runs from three inputs: the sleep mode, the on-demand setting and the peripheral clock requests. It holds the reference and feedback divider values, which can be write-protected. When the lock status bit goes from 0 to 1, it sets a sticky interrupt flag. When the PLL is stopped, the outputs are gated at once, but the lock status stays 1 for a fixed wind-down count before it reads 0.

Top module: `pll_seq_top`

## Requirements
- R1: Writing CTRL (address 0) with bit 0 = 1 raises `pll_en_o` one cycle after the write takes effect, provided the run decision is true. With bit 0 = 0 the PLL never starts.
- R2: `lock_o` (STATUS, address 1, bit 0) becomes 1 in the cycle after the first clock edge that samples `lock_i` high while starting up.
- R3: While `lock_o` is 0 after a start-up, every output clock is held low. Once the PLL is locked, output n toggles only if CTRL bit 8+n is 1.
- R4: The interrupt flag (INTFLAG, address 2, bit 0; also `irq_o`) is set one cycle after `lock_o` rises.
- R5: Writing INTFLAG with bit 0 = 1 clears the flag. If a rise event happens in the same cycle, the set takes priority and the flag stays 1.
- R6: A CTRL write changes the on-demand bit (bit 1) only if the enable bit read 0 before that write. Otherwise the on-demand bit keeps its old value.
- R7: With enable at 1, sleep mode 3 (backup) always stops the PLL. In modes 0, 1 and 2 (active, idle, standby) the PLL runs when on-demand is 0. When on-demand is 1, it runs only while any `periph_req_i` bit is 1.
- R8: While CTRL bit 6 (write lock) is 1, writes to REFDIV (address 3, bits 5:0) and FBDIV (address 4, bits 9:0) are ignored. While that bit is 0, those writes update `ref_div_o` and `fb_div_o`.
- R9: When the run decision drops while the PLL is locked, all outputs are gated at once. `lock_o` then stays 1 for WIND_CYC more cycles, and `pll_en_o` falls at the same time as `lock_o`.
- R10: The reference select (CTRL bits 3:2) accepts the values 0, 1 and 2; a write of 3 keeps the previous value. The bandwidth select (CTRL bits 5:4) stores any value.
- R11: If `lock_i` drops while the PLL is locked, `lock_o` goes to 0 and the outputs are gated, while `pll_en_o` stays 1. The sequencer then waits for a new lock.
- R12: After reset, all CTRL fields are 0, the flag is 0, `lock_o` and `pll_en_o` are 0, REFDIV reads 1 and FBDIV reads 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for registers and sequencer |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| lock_i | input | 1 | Lock indication from the analog macro, synchronous to clk |
| sleep_mode_i | input | 2 | 0 active, 1 idle, 2 standby, 3 backup |
| periph_req_i | input | NUM_REQ | Peripheral clock requests |
| pll_clk_i | input | NUM_OUT | Raw per-output clocks from the macro |
| pll_en_o | output | 1 | Analog enable |
| ref_sel_o | output | 2 | Reference source select |
| bw_sel_o | output | 2 | Loop bandwidth select |
| ref_div_o | output | 6 | Reference divider value |
| fb_div_o | output | 10 | Feedback divider value |
| lock_o | output | 1 | Lock status |
| irq_o | output | 1 | Lock-rise interrupt flag |
| gclk_o | output | NUM_OUT | Gated output clocks |

## Verification
The checker evaluates five rules on every cycle:
- the flag is set after a status rise;
- a clear write with no rise empties the flag;
- an on-demand write while enabled is discarded;
- the analog enable falls in backup mode;
- divider writes are dropped while protected.

Some behaviours depend on the exact cycle count or on clocks from other domains, so only the bench scenarios show them. These are the lock latency, the wind-down length, the per-output toggling before and after lock, the set-wins-over-clear collision, the relock after a lost lock and the settled run decision across random sleep and request patterns.

// File: rtl/pll_seq_pkg.sv
// Shared constants and types for the PLL enable and lock sequencer.
// Assumes a 16-bit register data path and a 3-bit address.
package pll_seq_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
    localparam logic [ADDR_W-1:0] A_IFLAG  = 3'd2;
    localparam logic [ADDR_W-1:0] A_REFDIV = 3'd3;
    localparam logic [ADDR_W-1:0] A_FBDIV  = 3'd4;

    // CTRL field positions
    localparam int B_EN     = 0;
    localparam int B_OD     = 1;
    localparam int B_REF    = 2;
    localparam int B_BW     = 4;
    localparam int B_WLOCK  = 6;
    localparam int B_OUTEN  = 8;

    typedef enum logic [1:0] {
        SLP_ACTIVE  = 2'd0,
        SLP_IDLE    = 2'd1,
        SLP_STANDBY = 2'd2,
        SLP_BACKUP  = 2'd3
    } sleep_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_START = 2'd1,
        ST_LOCK  = 2'd2,
        ST_WIND  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pll_seq_regs.sv
// Register file of the sequencer: control fields, divider values and the
// lock-rise flag. Assumes single-cycle writes and a combinational read.
module pll_seq_regs
    import pll_seq_pkg::*;
#(
    parameter int NUM_OUT  = 4,
    parameter int REFDIV_W = 6,
    parameter int FBDIV_W  = 10,
    parameter int REFDIV_RST = 1,
    parameter int FBDIV_RST  = 21
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    input  logic                lock_st_i,
    input  logic                lock_rise_i,
    output logic                en_o,
    output logic                od_o,
    output logic [1:0]          ref_sel_o,
    output logic [1:0]          bw_sel_o,
    output logic                wlock_o,
    output logic [NUM_OUT-1:0]  out_en_o,
    output logic [REFDIV_W-1:0] ref_div_o,
    output logic [FBDIV_W-1:0]  fb_div_o,
    output logic                irq_o
);

    logic wr_ctrl, wr_ref, wr_fb, wr_flag;

    // Decode the write strobe per register.
    always_comb begin
        wr_ctrl = wr_en_i && (addr_i == A_CTRL);
        wr_ref  = wr_en_i && (addr_i == A_REFDIV);
        wr_fb   = wr_en_i && (addr_i == A_FBDIV);
        wr_flag = wr_en_i && (addr_i == A_IFLAG);
    end

    // Control fields; on-demand only while disabled, reserved ref code kept out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o      <= 1'b0;
            od_o      <= 1'b0;
            ref_sel_o <= 2'd0;
            bw_sel_o  <= 2'd0;
            wlock_o   <= 1'b0;
            out_en_o  <= '0;
        end else if (wr_ctrl) begin
            en_o     <= wdata_i[B_EN];
            bw_sel_o <= wdata_i[B_BW +: 2];
            wlock_o  <= wdata_i[B_WLOCK];
            out_en_o <= wdata_i[B_OUTEN +: NUM_OUT];
            if (!en_o)
                od_o <= wdata_i[B_OD];
            if (wdata_i[B_REF +: 2] != 2'd3)
                ref_sel_o <= wdata_i[B_REF +: 2];
        end
    end

    // Divider values, blocked by the write-lock bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_div_o <= REFDIV_W'(REFDIV_RST);
            fb_div_o  <= FBDIV_W'(FBDIV_RST);
        end else begin
            if (wr_ref && !wlock_o)
                ref_div_o <= wdata_i[REFDIV_W-1:0];
            if (wr_fb && !wlock_o)
                fb_div_o <= wdata_i[FBDIV_W-1:0];
        end
    end

    // Sticky lock-rise flag: set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else if (lock_rise_i)
            irq_o <= 1'b1;
        else if (wr_flag && wdata_i[0])
            irq_o <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_CTRL: begin
                rdata_o[B_EN]              = en_o;
                rdata_o[B_OD]              = od_o;
                rdata_o[B_REF +: 2]        = ref_sel_o;
                rdata_o[B_BW +: 2]         = bw_sel_o;
                rdata_o[B_WLOCK]           = wlock_o;
                rdata_o[B_OUTEN +: NUM_OUT] = out_en_o;
            end
            A_STATUS: rdata_o[0] = lock_st_i;
            A_IFLAG:  rdata_o[0] = irq_o;
            A_REFDIV: rdata_o[REFDIV_W-1:0] = ref_div_o;
            A_FBDIV:  rdata_o[FBDIV_W-1:0]  = fb_div_o;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/pll_seq_fsm.sv
// Run decision and start/lock/wind-down sequencing. Assumes lock_i is
// already synchronous to clk. Outputs are released only in the locked state.
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int NUM_REQ  = 4,
    parameter int WIND_CYC = 8,
    localparam int CNT_W   = $clog2(WIND_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               od_i,
    input  logic [1:0]         sleep_i,
    input  logic [NUM_REQ-1:0] req_i,
    input  logic               lock_i,
    output logic               pll_en_o,
    output logic               lock_st_o,
    output logic               release_o,
    output logic               lock_rise_o
);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_want;
    logic              lock_st_q;

    // Whether the PLL should be running in the current mode.
    always_comb begin
        run_want = en_i && (sleep_i != SLP_BACKUP) && (!od_i || (|req_i));
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (run_want) state_d = ST_START;
            ST_START: begin
                if (!run_want)   state_d = ST_OFF;
                else if (lock_i) state_d = ST_LOCK;
            end
            ST_LOCK: begin
                if (!run_want)   state_d = ST_WIND;
                else if (!lock_i) state_d = ST_START;
            end
            ST_WIND:  if (cnt_q == '0) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // State register and wind-down counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_WIND && state_d == ST_WIND)
                cnt_q <= CNT_W'(WIND_CYC - 1);
            else if (state_q == ST_WIND && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Registered copy of status for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_st_q <= 1'b0;
        else        lock_st_q <= lock_st_o;
    end

    // Outputs decoded from state.
    always_comb begin
        pll_en_o    = (state_q != ST_OFF);
        lock_st_o   = (state_q == ST_LOCK) || (state_q == ST_WIND);
        release_o   = (state_q == ST_LOCK);
        lock_rise_o = lock_st_o && !lock_st_q;
    end

endmodule

// File: rtl/pll_seq_cg.sv
// Glitch-free clock gate for one output. The enable is resynchronised into
// the output clock domain and held by a latch that is open while the clock
// is low. Assumes rst_n is held over several output clock periods.
module pll_seq_cg #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic en_i,
    output logic gclk_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   en_lat;

    // Bring the enable into the output clock domain.
    always_ff @(posedge clk_i) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], en_i};
    end

    // Hold the enable stable through the high phase.
    always_latch begin
        if (!clk_i) en_lat = sync_q[SYNC_STAGES-1];
    end

    assign gclk_o = clk_i & en_lat;

endmodule

// File: rtl/pll_seq_top.sv
// Top of the PLL enable and lock sequencer: register file, sequencer and
// one clock gate per output. Assumes lock_i is synchronous to clk.
module pll_seq_top
    import pll_seq_pkg::*;
#(
    parameter int NUM_OUT     = 4,
    parameter int NUM_REQ     = 4,
    parameter int WIND_CYC    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int REFDIV_W    = 6,
    parameter int FBDIV_W     = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [2:0]          addr_i,
    input  logic [15:0]         wdata_i,
    output logic [15:0]         rdata_o,
    input  logic                lock_i,
    input  logic [1:0]          sleep_mode_i,
    input  logic [NUM_REQ-1:0]  periph_req_i,
    input  logic [NUM_OUT-1:0]  pll_clk_i,
    output logic                pll_en_o,
    output logic [1:0]          ref_sel_o,
    output logic [1:0]          bw_sel_o,
    output logic [REFDIV_W-1:0] ref_div_o,
    output logic [FBDIV_W-1:0]  fb_div_o,
    output logic                lock_o,
    output logic                irq_o,
    output logic [NUM_OUT-1:0]  gclk_o
);

    logic               en_w, od_w, wlock_w, rise_w, rel_w;
    logic [NUM_OUT-1:0] out_en_w;

    pll_seq_regs #(
        .NUM_OUT (NUM_OUT),
        .REFDIV_W(REFDIV_W),
        .FBDIV_W (FBDIV_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rdata_o    (rdata_o),
        .lock_st_i  (lock_o),
        .lock_rise_i(rise_w),
        .en_o       (en_w),
        .od_o       (od_w),
        .ref_sel_o  (ref_sel_o),
        .bw_sel_o   (bw_sel_o),
        .wlock_o    (wlock_w),
        .out_en_o   (out_en_w),
        .ref_div_o  (ref_div_o),
        .fb_div_o   (fb_div_o),
        .irq_o      (irq_o)
    );

    pll_seq_fsm #(
        .NUM_REQ (NUM_REQ),
        .WIND_CYC(WIND_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_w),
        .od_i       (od_w),
        .sleep_i    (sleep_mode_i),
        .req_i      (periph_req_i),
        .lock_i     (lock_i),
        .pll_en_o   (pll_en_o),
        .lock_st_o  (lock_o),
        .release_o  (rel_w),
        .lock_rise_o(rise_w)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        pll_seq_cg #(.SYNC_STAGES(SYNC_STAGES)) u_cg (
            .clk_i (pll_clk_i[g]),
            .rst_n (rst_n),
            .en_i  (rel_w && out_en_w[g]),
            .gclk_o(gclk_o[g])
        );
    end

endmodule

// File: rtl/pll_seq_chk.sv
// Cycle-level rules of the sequencer, attached to the top by bind.
module pll_seq_chk #(
    parameter int REFDIV_W = 6,
    parameter int FBDIV_W  = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en_i,
    input logic [2:0]          addr_i,
    input logic [15:0]         wdata_i,
    input logic [1:0]          sleep_mode_i,
    input logic                pll_en_o,
    input logic                lock_o,
    input logic                irq_o,
    input logic                en_w,
    input logic                od_w,
    input logic                wlock_w,
    input logic                rise_w,
    input logic [REFDIV_W-1:0] ref_div_o,
    input logic [FBDIV_W-1:0]  fb_div_o
);

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w |=> irq_o);

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 3'd2 && wdata_i[0] && !rise_w) |=> !irq_o);

    // R6
    od_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 3'd0 && en_w) |=> $stable(od_w));

    // R7
    backup_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_mode_i == 2'd3 && !lock_o) |=> !pll_en_o);

    // R8
    refdiv_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 3'd3 && wlock_w) |=> $stable(ref_div_o));

    // R8
    fbdiv_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 3'd4 && wlock_w) |=> $stable(fb_div_o));

endmodule

bind pll_seq_top pll_seq_chk #(
    .REFDIV_W(REFDIV_W),
    .FBDIV_W (FBDIV_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .sleep_mode_i(sleep_mode_i),
    .pll_en_o    (pll_en_o),
    .lock_o      (lock_o),
    .irq_o       (irq_o),
    .en_w        (en_w),
    .od_w        (od_w),
    .wlock_w     (wlock_w),
    .rise_w      (rise_w),
    .ref_div_o   (ref_div_o),
    .fb_div_o    (fb_div_o)
);

// File: tb/sim_pll_seq_top.sv
// Bench for the PLL sequencer with a behavioural lock model.
module sim_pll_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_OUT    = 4;
    localparam int NUM_REQ    = 4;
    localparam int WIND_CYC   = 8;
    localparam int LOCK_DLY   = 5;

    logic               clk = 1'b0;
    logic               pclk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [2:0]         addr = '0;
    logic [15:0]        wdata = '0;
    logic [15:0]        rdata;
    logic               lock_in;
    logic [1:0]         sleep = 2'd0;
    logic [NUM_REQ-1:0] req = '0;
    logic               pll_en, lock_st, irq;
    logic [1:0]         ref_sel, bw_sel;
    logic [5:0]         ref_div;
    logic [9:0]         fb_div;
    logic [NUM_OUT-1:0] gclk;
    logic               kill_lock = 1'b0;
    int                 lk_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(CLK_PERIOD/5) pclk = ~pclk;

    pll_seq_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .lock_i      (lock_in),
        .sleep_mode_i(sleep),
        .periph_req_i(req),
        .pll_clk_i   ({NUM_OUT{pclk}}),
        .pll_en_o    (pll_en),
        .ref_sel_o   (ref_sel),
        .bw_sel_o    (bw_sel),
        .ref_div_o   (ref_div),
        .fb_div_o    (fb_div),
        .lock_o      (lock_st),
        .irq_o       (irq),
        .gclk_o      (gclk)
    );

    // Behavioural analog lock: asserts LOCK_DLY+1 cycles after enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !pll_en || kill_lock) begin
            lk_cnt  <= 0;
            lock_in <= 1'b0;
        end else if (lk_cnt == LOCK_DLY) begin
            lock_in <= 1'b1;
        end else begin
            lk_cnt <= lk_cnt + 1;
        end
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_cnt
        int c = 0;
        always @(posedge gclk[g]) c <= c + 1;
    end

    function automatic int edges(input int i);
        case (i)
            0: return g_cnt[0].c;
            1: return g_cnt[1].c;
            2: return g_cnt[2].c;
            default: return g_cnt[3].c;
        endcase
    endfunction

    function automatic logic run_exp(input logic od, input logic [1:0] m,
                                     input logic [NUM_REQ-1:0] r);
        return (m != 2'd3) && (!od || (r != '0));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a falling edge; write is taken at the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int s[NUM_OUT];
        int n;
        void'($urandom(32'd1357));
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(3'd0, d); chk("R12 ctrl", d, 0);
        rd(3'd3, d); chk("R12 refdiv", d, 1);
        rd(3'd4, d); chk("R12 fbdiv", d, 21);
        chk("R12 lock", lock_st, 0);
        chk("R12 pll_en", pll_en, 0);
        chk("R12 irq", irq, 0);

        // R1 start: enable, outputs 0 and 2
        wr(3'd0, 16'h0501);
        chk("R1 en before fsm", pll_en, 0);
        for (int i = 0; i < NUM_OUT; i++) s[i] = edges(i);
        @(negedge clk);
        chk("R1 pll_en", pll_en, 1);
        // R3 no output while waiting for lock
        while (!lock_in) @(negedge clk);
        chk("R2 lock not yet", lock_st, 0);
        for (int i = 0; i < NUM_OUT; i++) chk("R3 gated pre-lock", edges(i) - s[i], 0);
        @(negedge clk);
        chk("R2 lock", lock_st, 1);
        chk("R4 flag not yet", irq, 0);
        @(negedge clk);
        chk("R4 flag set", irq, 1);
        cyc(4);
        for (int i = 0; i < NUM_OUT; i++) s[i] = edges(i);
        cyc(10);
        chk("R3 out0 runs", (edges(0) - s[0]) > 0, 1);
        chk("R3 out1 off", edges(1) - s[1], 0);
        chk("R3 out2 runs", (edges(2) - s[2]) > 0, 1);
        chk("R3 out3 off", edges(3) - s[3], 0);

        // R5 clear
        wr(3'd2, 16'h0001);
        chk("R5 clear", irq, 0);

        // R6 on-demand ignored while enabled
        wr(3'd0, 16'h0503);
        rd(3'd0, d); chk("R6 od ignored", d[1], 0);
        chk("R6 still running", lock_st, 1);

        // R10 reference/bandwidth select
        wr(3'd0, 16'h0539);
        chk("R10 ref=2", ref_sel, 2);
        chk("R10 bw=3", bw_sel, 3);
        wr(3'd0, 16'h050D);
        chk("R10 ref kept", ref_sel, 2);
        chk("R10 bw=0", bw_sel, 0);

        // R8 divider write lock
        wr(3'd3, 16'd17);  chk("R8 refdiv open", ref_div, 17);
        wr(3'd4, 16'd300); chk("R8 fbdiv open", fb_div, 300);
        wr(3'd0, 16'h0549);
        wr(3'd3, 16'd33);  chk("R8 refdiv locked", ref_div, 17);
        wr(3'd4, 16'd500); chk("R8 fbdiv locked", fb_div, 300);
        wr(3'd0, 16'h0509);
        wr(3'd3, 16'd40);  chk("R8 refdiv reopened", ref_div, 40);

        // R11 loss of lock, then R5 set wins over clear on relock
        kill_lock = 1'b1;
        @(negedge clk);
        kill_lock = 1'b0;
        @(negedge clk);
        chk("R11 lock lost", lock_st, 0);
        chk("R11 en kept", pll_en, 1);
        cyc(2);
        for (int i = 0; i < NUM_OUT; i++) s[i] = edges(i);
        cyc(2);
        chk("R11 out0 gated", edges(0) - s[0], 0);
        while (!(lock_in && !lock_st)) @(negedge clk);
        @(negedge clk);
        wr(3'd2, 16'h0001);
        chk("R5 set wins", irq, 1);
        chk("R11 relocked", lock_st, 1);

        // R9 wind-down
        cyc(4);
        wr(3'd0, 16'h0508);
        chk("R9 lock held", lock_st, 1);
        cyc(2);
        for (int i = 0; i < NUM_OUT; i++) s[i] = edges(i);
        cyc(3);
        chk("R9 out0 gated", edges(0) - s[0], 0);
        chk("R9 out2 gated", edges(2) - s[2], 0);
        chk("R9 en held", pll_en, 1);
        n = 5;
        while (lock_st) begin n++; @(negedge clk); end
        chk("R9 wind length", n, WIND_CYC + 1);
        chk("R9 en off", pll_en, 0);

        // R7 random run decision, on-demand 0
        wr(3'd0, 16'h0001);
        for (int it = 0; it < 15; it++) begin
            sleep = 2'($urandom_range(0, 3));
            req = NUM_REQ'($urandom);
            cyc(30);
            chk("R7 od0 en", pll_en, run_exp(1'b0, sleep, req));
            chk("R7 od0 lock", lock_st, run_exp(1'b0, sleep, req));
        end
        // R6 on-demand accepted while disabled
        wr(3'd0, 16'h0000);
        wr(3'd0, 16'h0002);
        rd(3'd0, d); chk("R6 od accepted", d[1], 1);
        wr(3'd0, 16'h0003);
        for (int it = 0; it < 15; it++) begin
            sleep = 2'($urandom_range(0, 3));
            req = ($urandom_range(0, 1) == 0) ? '0 : NUM_REQ'($urandom);
            cyc(30);
            chk("R7 od1 en", pll_en, run_exp(1'b1, sleep, req));
            chk("R7 od1 lock", lock_st, run_exp(1'b1, sleep, req));
        end
        // R1 disabled never starts
        sleep = 2'd0; req = '1;
        wr(3'd0, 16'h0000);
        cyc(30);
        chk("R1 disabled", pll_en, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule